// File: doc/BRIEF.md
# Tick-Driven Dual Timer/Counter

This peripheral holds one or two 32-bit timer/counters behind a simple word-addressed register bus. Each timer has a control/status word, a load word and a live counter word. Software picks the count direction and can turn on auto-reload and the interrupt. The counters move only on cycles where the `tick` input is high, so a shared prescaler can set the time base for many blocks.

A write to the control word that has the enable bit set copies the load value into the counter and starts it, even if the timer is already running. When a timer reaches its terminal count, its expiry flag inside the control word goes high. With auto-reload on, the counter reloads and keeps going. Otherwise it stops. All timers drive one registered interrupt line.

Top module: `tick_timer_pair`

## Requirements
- R1: Each timer takes four words. `addr[1:0]` picks the register: 0 is control, 1 is load, 2 is the counter, and 3 reads zero and ignores writes. The upper address bits pick the timer. Read data is registered and appears on `rdata` in the cycle after `rd_en`, holding the value from the cycle of the read.
- R2: The control word stores bits [10:0] and reads zero above them. Bit 0 mode, bit 2 generate, bit 3 capture, bit 5 load, bit 9 PWM and bit 10 all-enable are stored and read back with no other effect. Bit 1 is direction, bit 4 auto-reload, bit 6 interrupt enable, bit 7 enable and bit 8 expiry flag.
- R3: A control write with bit 7 = 1 loads the counter from the load word and starts it, even when it is already running. A control write with bit 7 = 0 stops the counter and leaves its value as it is.
- R4: With bit 1 = 1 the counter decrements on each tick. It expires on the tick taken while it is zero, so a load value L expires on tick L+1.
- R5: With bit 1 = 0 the counter increments from the load value. It expires on the tick taken while it is 0xFFFFFFFF, so a load value 0xFFFFFFFF-L expires on tick L+1.
- R6: Expiry sets bit 8. If bit 4 is set, the counter reloads from the load word and keeps running. If not, it stops and holds its terminal value.
- R7: Software cannot set bit 8. A control write with bit 8 = 1 clears it, and a write with bit 8 = 0 leaves it as it is.
- R8: `irq` is registered. It is high one cycle after any timer has both bit 8 and bit 6 set.
- R9: The counter changes only on a tick or a control write. Writes to the counter word (offset 2) are ignored.
- R10: Reset clears every register, stops all counters and drives `irq` and `rdata` low.
- R11: With `NUM_TIMERS` = 1 the address is two bits wide, and only that single timer is decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for running timers |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address (timer select above bit 1) |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |
| irq | output | 1 | Shared registered interrupt |

## Verification
A register write takes effect at the clock edge where it is sampled. Read data for that write is due one edge after `rd_en`, and `irq` follows a change in the flag by one more edge. The bench drives each strobe for one cycle at a falling edge and samples outputs at the next falling edge. Every irq check follows a read, so the extra edge has already passed. Ticks are given as exact counts of high cycles, with `tick` held low during register access. This makes each expiry land on a known tick: terminal value reached after L ticks, flag set on tick L+1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W = 11;
  localparam int B_MODE = 0;
  localparam int B_DOWN = 1;
  localparam int B_GEN  = 2;
  localparam int B_CAPT = 3;
  localparam int B_ARLD = 4;
  localparam int B_LDB  = 5;
  localparam int B_IE   = 6;
  localparam int B_EN   = 7;
  localparam int B_FLAG = 8;
  localparam int B_PWM  = 9;
  localparam int B_ALL  = 10;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_LOAD  = 2'd1,
    REG_COUNT = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              ctrl_we,
  input  logic              load_we,
  input  logic [WIDTH-1:0]  wdata,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [WIDTH-1:0]  load_o,
  output logic [WIDTH-1:0]  count_o,
  output logic              pend_o
);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [WIDTH-1:0]  load_q;
  logic [WIDTH-1:0]  cnt_q;
  logic              run_q;
  logic              down;
  logic              at_end;
  logic              step;
  logic              expire;

  assign down   = ctrl_q[B_DOWN];
  assign at_end = down ? (cnt_q == '0) : (cnt_q == ALL_ONES);
  assign step   = run_q & tick;
  assign expire = step & at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      if (load_we) load_q <= wdata;
      if (ctrl_we) begin
        ctrl_q[B_FLAG-1:0]        <= wdata[B_FLAG-1:0];
        ctrl_q[CTRL_W-1:B_FLAG+1] <= wdata[CTRL_W-1:B_FLAG+1];
      end
      ctrl_q[B_FLAG] <= expire | (ctrl_q[B_FLAG] & ~(ctrl_we & wdata[B_FLAG]));
      if (ctrl_we) begin
        run_q <= wdata[B_EN];
        if (wdata[B_EN]) cnt_q <= load_q;
      end else if (step) begin
        if (at_end) begin
          if (ctrl_q[B_ARLD]) cnt_q <= load_q;
          else                run_q <= 1'b0;
        end else begin
          cnt_q <= down ? cnt_q - 1'b1 : cnt_q + 1'b1;
        end
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign load_o  = load_q;
  assign count_o = cnt_q;
  assign pend_o  = ctrl_q[B_FLAG] & ctrl_q[B_IE];

  AST_NO_SW_SET: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !ctrl_q[B_FLAG] && !step) |=> !ctrl_q[B_FLAG]); // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && wdata[B_EN]) |=> (run_q && cnt_q == $past(load_q))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_we && !step) |=> $stable(cnt_q)); // R9
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_we && step && down && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_we && step && !down && cnt_q != ALL_ONES) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R5
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int WIDTH      = 32,
  parameter int ADDR_W     = 3
) (
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [NUM_TIMERS-1:0][CTRL_W-1:0]   ctrl_all,
  input  logic [NUM_TIMERS-1:0][WIDTH-1:0]    load_all,
  input  logic [NUM_TIMERS-1:0][WIDTH-1:0]    cnt_all,
  output logic [WIDTH-1:0]                    data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if ((addr >> 2) == ADDR_W'(i)) begin
        case (reg_sel_e'(addr[1:0]))
          REG_CTRL:  data = WIDTH'(ctrl_all[i]);
          REG_LOAD:  data = load_all[i];
          REG_COUNT: data = cnt_all[i];
          default:   data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
  import tmr_pkg::*;
#(
  parameter int NUM_TIMERS = 2,
  parameter int WIDTH      = 32,
  localparam int TSEL_W    = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 0,
  localparam int ADDR_W    = 2 + TSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              irq
);
  logic [NUM_TIMERS-1:0][CTRL_W-1:0] ctrl_all;
  logic [NUM_TIMERS-1:0][WIDTH-1:0]  load_all;
  logic [NUM_TIMERS-1:0][WIDTH-1:0]  cnt_all;
  logic [NUM_TIMERS-1:0]             pend;
  logic [WIDTH-1:0]                  rd_mux;
  reg_sel_e                          sel;

  assign sel = reg_sel_e'(addr[1:0]);

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    logic hit;
    assign hit = wr_en && ((addr >> 2) == ADDR_W'(i));
    tmr_unit #(.WIDTH(WIDTH)) u_unit (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .ctrl_we (hit && sel == REG_CTRL),
      .load_we (hit && sel == REG_LOAD),
      .wdata   (wdata),
      .ctrl_o  (ctrl_all[i]),
      .load_o  (load_all[i]),
      .count_o (cnt_all[i]),
      .pend_o  (pend[i])
    );
  end

  tmr_rdmux #(.NUM_TIMERS(NUM_TIMERS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rdmux (
    .addr     (addr),
    .ctrl_all (ctrl_all),
    .load_all (load_all),
    .cnt_all  (cnt_all),
    .data     (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= |pend;
    end
  end

  AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|pend))); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R1
endmodule

// File: tb/tick_timer_pair_test.sv
module tick_timer_pair_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata1;
  logic        irq, irq1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_pair #(.NUM_TIMERS(2), .WIDTH(32)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  tick_timer_pair #(.NUM_TIMERS(1), .WIDTH(32)) uut1 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr[1:0]), .wdata(wdata), .rdata(rdata1), .irq(irq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic expect_rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10: reset state
    for (int a = 0; a < 8; a++) expect_rd("R10 reset regs", 3'(a), 32'h0);
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    chk("R10 single-timer rdata", rdata1, 32'h0);

    // R2: storage of control bits without enable
    wr(3'd0, 32'hFFFF_F67F);
    expect_rd("R2 ctrl readback", 3'd0, 32'h0000_067F);
    wr(3'd0, 32'h0);

    // R4/R9: down count, idle hold, counter write ignored
    wr(3'd1, 32'd5);
    wr(3'd0, 32'h82);
    expect_rd("R3 start loads counter", 3'd2, 32'd5);
    ticks(3);
    expect_rd("R4 down after 3 ticks", 3'd2, 32'd2);
    repeat (4) @(negedge clk);
    expect_rd("R9 no tick no change", 3'd2, 32'd2);
    wr(3'd2, 32'h99);
    expect_rd("R9 counter write ignored", 3'd2, 32'd2);
    ticks(2);
    expect_rd("R4 at zero, no flag", 3'd0, 32'h82);
    ticks(1);
    expect_rd("R6 flag on expiry", 3'd0, 32'h182);
    ticks(5);
    expect_rd("R6 stopped at zero", 3'd2, 32'd0);
    chk("R8 irq off when ie clear", {31'b0, irq}, 32'h0);

    // R7/R8: flag kept by write of 0, cleared by write of 1
    wr(3'd0, 32'h42);
    expect_rd("R7 flag kept by write 0", 3'd0, 32'h142);
    chk("R8 irq asserted", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h142);
    expect_rd("R7 flag cleared by write 1", 3'd0, 32'h042);
    chk("R8 irq released", {31'b0, irq}, 32'h0);

    // R6: auto-reload
    wr(3'd1, 32'd2);
    wr(3'd0, 32'hD2);
    ticks(3);
    expect_rd("R6 reload after expiry", 3'd2, 32'd2);
    ticks(1);
    expect_rd("R6 keeps running", 3'd2, 32'd1);
    expect_rd("R6 flag set with reload", 3'd0, 32'h1D2);
    chk("R8 irq from auto-reload", {31'b0, irq}, 32'h1);
    wr(3'd0, 32'h1D2);
    expect_rd("R3 restart while running", 3'd2, 32'd2);
    expect_rd("R7 clear on restart", 3'd0, 32'hD2);
    wr(3'd0, 32'h100);
    expect_rd("R3 disable", 3'd0, 32'h0);
    chk("R8 irq low after disable", {31'b0, irq}, 32'h0);

    // R5: up count on second timer
    wr(3'd5, 32'hFFFF_FFFD);
    wr(3'd4, 32'h80);
    ticks(2);
    expect_rd("R5 up reaches all ones", 3'd6, 32'hFFFF_FFFF);
    expect_rd("R5 no flag before expiry", 3'd4, 32'h80);
    ticks(1);
    expect_rd("R5 flag after all ones", 3'd4, 32'h180);
    ticks(2);
    expect_rd("R6 up stopped", 3'd6, 32'hFFFF_FFFF);
    chk("R8 irq off timer1 ie clear", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'h40);
    expect_rd("R7 timer1 flag kept", 3'd4, 32'h140);
    chk("R8 irq from timer1", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h100);
    expect_rd("R7 timer1 flag cleared", 3'd4, 32'h0);
    chk("R8 irq low again", {31'b0, irq}, 32'h0);

    // R3: restart and stop on timer1
    wr(3'd5, 32'd10);
    wr(3'd4, 32'h82);
    ticks(4);
    expect_rd("R4 timer1 down", 3'd6, 32'd6);
    wr(3'd4, 32'h82);
    expect_rd("R3 reload on running timer", 3'd6, 32'd10);
    ticks(1);
    wr(3'd4, 32'h02);
    ticks(3);
    expect_rd("R3 stop holds value", 3'd6, 32'd9);

    // R1: offset 3 reads zero, ignores writes
    wr(3'd3, 32'hABCD);
    wr(3'd7, 32'h1234);
    expect_rd("R1 offset3 t0", 3'd3, 32'h0);
    expect_rd("R1 offset3 t1", 3'd7, 32'h0);

    // R4/R5 sweep over load values, directions and timers
    for (int t = 0; t < 2; t++) begin
      for (int dn = 0; dn < 2; dn++) begin
        for (int l = 0; l < 6; l++) begin
          logic [2:0]  base;
          logic [31:0] ld, term, cw;
          base = 3'(t * 4);
          ld   = (dn != 0) ? 32'(l) : (32'hFFFF_FFFF - 32'(l));
          term = (dn != 0) ? 32'h0 : 32'hFFFF_FFFF;
          cw   = (dn != 0) ? 32'h82 : 32'h80;
          wr(base + 3'd1, ld);
          wr(base, cw | 32'h100);
          ticks(l);
          expect_rd(dn != 0 ? "R4 sweep no early flag" : "R5 sweep no early flag", base, cw);
          expect_rd(dn != 0 ? "R4 sweep terminal" : "R5 sweep terminal", base + 3'd2, term);
          ticks(1);
          expect_rd(dn != 0 ? "R4 sweep expiry" : "R5 sweep expiry", base, cw | 32'h100);
        end
      end
    end

    // R11: single-timer build decodes only two address bits
    wr(3'd5, 32'h0000_1234);
    rd(3'd5, v);
    chk("R1 timer1 load readback", v, 32'h1234);
    chk("R11 single-timer decode", rdata1, 32'h1234);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule